// File: doc/BRIEF.md
# Machine-Mode Interrupt Trap Controller

This block keeps the machine-mode trap state of a small RISC-V style core: the global interrupt enable, its saved copy, the saved privilege mode, the trap-vector register, the saved return address and the cause register. Each cycle it checks whether an enabled, pending interrupt may be taken. When one is taken it raises a take strobe and a pc redirect to the handler. The save of enable, privilege and pc happens on the same clock edge. When the core signals an MRET, the block redirects to the saved pc and restores the enable and privilege from their saved copies.

Three interrupt lines are handled: software (bit 0), timer (bit 1) and external (bit 2). The core writes the status, trap-vector and saved-pc registers through plain write ports. Decisions are combinational on the current cycle's inputs. State changes land on the next rising clock edge.

Top module: `mtrap_ctrl`

## Requirements
- R1: While the global enable (status bit 3) is 0, `take_trap` stays 0 for every combination of pending and enable lines.
- R2: While the global enable is 1 and `irq_pend & irq_en` is nonzero, `take_trap` and `redir_valid` are 1 in that same cycle. The winning source is chosen with external above software above timer. Its cause code is 11 (external), 3 (software) or 7 (timer).
- R3: On a taken interrupt, the previous-enable bit receives the old global enable and the global enable clears on the same edge. An interrupt that stays pending is therefore not taken again on the next cycle.
- R4: During a taken interrupt, `new_priv` is 3 (machine). The previous-privilege field stores `cur_priv` as legalized by R11.
- R5: On a taken interrupt, the saved pc register stores `pc_i` with bits 1:0 cleared. `cause_o` becomes bit 31 set with the cause code in the low bits.
- R6: The trap-vector mode is bits 1:0 of the vector register and the base is the register with those bits cleared. Mode 1 gives a target of base + 4 × cause code. Modes 0, 2 and 3 give a target equal to the base.
- R7: On `mret_i`, `redir_valid` is 1 with `redir_pc` equal to the saved pc and `new_priv` equal to the previous-privilege field. On the next edge, the global enable takes the previous-enable value, the previous-enable bit becomes 1 and the previous-privilege field becomes the lowest supported mode: 0 when user mode exists, otherwise 3.
- R8: When `mret_i` and a takeable interrupt coincide, MRET wins and `take_trap` is 0. The interrupt is evaluated on the next cycle using the restored enable.
- R9: A status write (bits 3 enable, 7 previous enable, 12:11 previous privilege) lets software re-enable interrupts inside a handler. A taken interrupt or an MRET in the same cycle overrides the status write.
- R10: Writes to the saved pc register drop bits 1:0, which always read as zero.
- R11: A previous-privilege value of 3 is kept and any other value is stored as 0 when user mode is supported. Without user mode, the field always holds 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | 3 | Pending lines: bit0 software, bit1 timer, bit2 external |
| irq_en | input | 3 | Per-source enables, same bit order |
| pc_i | input | XLEN | pc of the instruction being interrupted |
| cur_priv | input | 2 | Current privilege mode (0 user, 3 machine) |
| mret_i | input | 1 | MRET executes this cycle |
| st_we | input | 1 | Status register write strobe |
| st_wdata | input | XLEN | Status write data |
| tvec_we | input | 1 | Trap-vector write strobe |
| tvec_wdata | input | XLEN | Trap-vector write data |
| epc_we | input | 1 | Saved-pc write strobe |
| epc_wdata | input | XLEN | Saved-pc write data |
| take_trap | output | 1 | Interrupt taken this cycle |
| redir_valid | output | 1 | pc redirect this cycle (trap or MRET) |
| redir_pc | output | XLEN | Redirect target |
| new_priv | output | 2 | Privilege mode in effect after this cycle |
| cause_o | output | XLEN | Cause register |

## Verification
A sweep covers every pending/enable combination in all four vector modes with the enable both clear and set. A wrong priority order or vector arithmetic shows up as a bad cause offset in the target, and a leak through a cleared enable shows up as a spurious take. Directed sequences check that a still-pending line is not retaken right after entry. A design that skipped clearing the enable would loop on the same interrupt. The MRET-plus-interrupt collision is checked with both restored enable values. A design that let the interrupt win would lose the return, and one that used the stale enable would take it a cycle early or not at all. Misaligned saved-pc writes and illegal privilege writes are driven and then observed through the MRET redirect and `new_priv`.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
    localparam logic [1:0] PRIV_USER    = 2'b00;
    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    localparam int unsigned NUM_SRC   = 3;
    localparam int unsigned CODE_W    = 4;

    localparam logic [CODE_W-1:0] CODE_SOFT  = 4'd3;
    localparam logic [CODE_W-1:0] CODE_TIMER = 4'd7;
    localparam logic [CODE_W-1:0] CODE_EXT   = 4'd11;

    localparam int unsigned SRC_SOFT  = 0;
    localparam int unsigned SRC_TIMER = 1;
    localparam int unsigned SRC_EXT   = 2;

    localparam int unsigned ST_GIE_BIT  = 3;
    localparam int unsigned ST_PGIE_BIT = 7;
    localparam int unsigned ST_PPRV_LO  = 11;

    localparam logic [1:0] VMODE_VECTORED = 2'b01;

    function automatic logic [1:0] legal_priv(input logic [1:0] req, input bit has_user);
        if (!has_user)             return PRIV_MACHINE;
        else if (req == PRIV_MACHINE) return PRIV_MACHINE;
        else                       return PRIV_USER;
    endfunction
endpackage

// File: rtl/mtrap_irq_sel.sv
module mtrap_irq_sel
    import mtrap_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               gie_i,
    output logic               req_o,
    output logic [CODE_W-1:0]  code_o
);
    logic [NUM_SRC-1:0] live;

    always_comb begin
        live   = pend_i & en_i;
        req_o  = gie_i && (live != '0);
        code_o = '0;
        if (live[SRC_EXT])        code_o = CODE_EXT;
        else if (live[SRC_SOFT])  code_o = CODE_SOFT;
        else if (live[SRC_TIMER]) code_o = CODE_TIMER;
    end
endmodule

// File: rtl/mtrap_vec_calc.sv
module mtrap_vec_calc
    import mtrap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0]   tvec_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   target_o
);
    localparam int unsigned PAD_W = XLEN - CODE_W - 2;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {tvec_i[XLEN-1:2], 2'b00};
        offset = {{PAD_W{1'b0}}, code_i, 2'b00};
        if (tvec_i[1:0] == VMODE_VECTORED) target_o = base + offset;
        else                               target_o = base;
    end
endmodule

// File: rtl/mtrap_state.sv
module mtrap_state
    import mtrap_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter bit          HAS_USER   = 1'b1,
    parameter logic [XLEN-1:0] TVEC_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              mret_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [1:0]        cur_priv,
    input  logic              st_we,
    input  logic [XLEN-1:0]   st_wdata,
    input  logic              tvec_we,
    input  logic [XLEN-1:0]   tvec_wdata,
    input  logic              epc_we,
    input  logic [XLEN-1:0]   epc_wdata,
    output logic              gie_o,
    output logic              pgie_o,
    output logic [1:0]        pprv_o,
    output logic [XLEN-1:0]   tvec_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o
);
    localparam int unsigned CPAD_W = XLEN - 1 - CODE_W;
    localparam logic [1:0]  LOWEST = HAS_USER ? PRIV_USER : PRIV_MACHINE;

    typedef struct packed {
        logic            gie;
        logic            pgie;
        logic [1:0]      pprv;
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
    } trap_state_t;

    trap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mret_i) begin
            st_d.gie  = st_q.pgie;
            st_d.pgie = 1'b1;
            st_d.pprv = LOWEST;
        end else if (take_i) begin
            st_d.pgie  = st_q.gie;
            st_d.gie   = 1'b0;
            st_d.pprv  = legal_priv(cur_priv, HAS_USER);
            st_d.cause = {1'b1, {CPAD_W{1'b0}}, code_i};
        end else if (st_we) begin
            st_d.gie  = st_wdata[ST_GIE_BIT];
            st_d.pgie = st_wdata[ST_PGIE_BIT];
            st_d.pprv = legal_priv(st_wdata[ST_PPRV_LO +: 2], HAS_USER);
        end
        if (tvec_we) st_d.tvec = tvec_wdata;
        if (take_i && !mret_i)  st_d.epc = {pc_i[XLEN-1:2], 2'b00};
        else if (epc_we)        st_d.epc = {epc_wdata[XLEN-1:2], 2'b00};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gie   <= 1'b0;
            st_q.pgie  <= 1'b0;
            st_q.pprv  <= PRIV_MACHINE;
            st_q.tvec  <= TVEC_RST;
            st_q.epc   <= '0;
            st_q.cause <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gie_o   = st_q.gie;
    assign pgie_o  = st_q.pgie;
    assign pprv_o  = st_q.pprv;
    assign tvec_o  = st_q.tvec;
    assign epc_o   = st_q.epc;
    assign cause_o = st_q.cause;
endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter bit          HAS_USER = 1'b1,
    parameter logic [XLEN-1:0] TVEC_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      irq_pend,
    input  logic [2:0]      irq_en,
    input  logic [XLEN-1:0] pc_i,
    input  logic [1:0]      cur_priv,
    input  logic            mret_i,
    input  logic            st_we,
    input  logic [XLEN-1:0] st_wdata,
    input  logic            tvec_we,
    input  logic [XLEN-1:0] tvec_wdata,
    input  logic            epc_we,
    input  logic [XLEN-1:0] epc_wdata,
    output logic            take_trap,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic [1:0]      new_priv,
    output logic [XLEN-1:0] cause_o
);
    logic              gie_q, pgie_q;
    logic [1:0]        pprv_q;
    logic [XLEN-1:0]   tvec_q, epc_q;
    logic              irq_req;
    logic [CODE_W-1:0] irq_code;
    logic [XLEN-1:0]   vec_target;

    mtrap_irq_sel u_sel (
        .pend_i (irq_pend),
        .en_i   (irq_en),
        .gie_i  (gie_q),
        .req_o  (irq_req),
        .code_o (irq_code)
    );

    mtrap_vec_calc #(.XLEN(XLEN)) u_vec (
        .tvec_i   (tvec_q),
        .code_i   (irq_code),
        .target_o (vec_target)
    );

    always_comb begin
        take_trap   = irq_req && !mret_i;
        redir_valid = take_trap || mret_i;
        redir_pc    = '0;
        new_priv    = cur_priv;
        if (mret_i) begin
            redir_pc = epc_q;
            new_priv = pprv_q;
        end else if (take_trap) begin
            redir_pc = vec_target;
            new_priv = PRIV_MACHINE;
        end
    end

    mtrap_state #(.XLEN(XLEN), .HAS_USER(HAS_USER), .TVEC_RST(TVEC_RST)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take_trap),
        .code_i     (irq_code),
        .mret_i     (mret_i),
        .pc_i       (pc_i),
        .cur_priv   (cur_priv),
        .st_we      (st_we),
        .st_wdata   (st_wdata),
        .tvec_we    (tvec_we),
        .tvec_wdata (tvec_wdata),
        .epc_we     (epc_we),
        .epc_wdata  (epc_wdata),
        .gie_o      (gie_q),
        .pgie_o     (pgie_q),
        .pprv_o     (pprv_q),
        .tvec_o     (tvec_q),
        .epc_o      (epc_q),
        .cause_o    (cause_o)
    );
endmodule

// File: rtl/mtrap_chk.sv
module mtrap_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_trap,
    input logic            mret_i,
    input logic [1:0]      new_priv,
    input logic [XLEN-1:0] pc_i,
    input logic            gie_q,
    input logic            pgie_q,
    input logic [XLEN-1:0] epc_q
);
    localparam logic [XLEN-1:0] ALIGN = ~{{(XLEN-2){1'b0}}, 2'b11};

    a_r1_gated_by_gie: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !take_trap);

    a_r3_entry_saves_enable: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (!gie_q && pgie_q));

    a_r4_entry_machine_mode: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> (new_priv == 2'b11));

    a_r5_entry_saves_pc: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (epc_q == ($past(pc_i) & ALIGN)));

    a_r7_mret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        mret_i |=> (gie_q == $past(pgie_q) && pgie_q));

    a_r8_mret_wins: assert property (@(posedge clk) disable iff (!rst_n)
        mret_i |-> !take_trap);

    a_r10_epc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        epc_q[1:0] == 2'b00);
endmodule

bind mtrap_ctrl mtrap_chk #(.XLEN(XLEN)) i_mtrap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_trap (take_trap),
    .mret_i    (mret_i),
    .new_priv  (new_priv),
    .pc_i      (pc_i),
    .gie_q     (gie_q),
    .pgie_q    (pgie_q),
    .epc_q     (epc_q)
);

// File: tb/test_mtrap_ctrl.sv
module test_mtrap_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_pend = '0, irq_en = '0;
    logic [31:0] pc_i = '0;
    logic [1:0]  cur_priv = 2'b00;
    logic        mret_i = 1'b0;
    logic        st_we = 1'b0, tvec_we = 1'b0, epc_we = 1'b0;
    logic [31:0] st_wdata = '0, tvec_wdata = '0, epc_wdata = '0;
    logic        take_trap, redir_valid;
    logic [31:0] redir_pc, cause_o;
    logic [1:0]  new_priv;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtrap_ctrl i_mtrap_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
        .pc_i(pc_i), .cur_priv(cur_priv), .mret_i(mret_i),
        .st_we(st_we), .st_wdata(st_wdata), .tvec_we(tvec_we), .tvec_wdata(tvec_wdata),
        .epc_we(epc_we), .epc_wdata(epc_wdata),
        .take_trap(take_trap), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .new_priv(new_priv), .cause_o(cause_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] st_word(input logic gie, input logic pgie, input logic [1:0] pp);
        logic [31:0] w;
        w = '0;
        w[3] = gie;
        w[7] = pgie;
        w[12:11] = pp;
        return w;
    endfunction

    task automatic wr_status(input logic gie, input logic pgie, input logic [1:0] pp);
        st_we = 1'b1; st_wdata = st_word(gie, pgie, pp);
        tick();
        st_we = 1'b0;
    endtask

    task automatic wr_tvec(input logic [31:0] v);
        tvec_we = 1'b1; tvec_wdata = v;
        tick();
        tvec_we = 1'b0;
    endtask

    task automatic wr_epc(input logic [31:0] v);
        epc_we = 1'b1; epc_wdata = v;
        tick();
        epc_we = 1'b0;
    endtask

    function automatic logic [3:0] exp_code(input logic [2:0] live);
        if (live[2])      return 4'd11;
        else if (live[0]) return 4'd3;
        else if (live[1]) return 4'd7;
        else              return 4'd0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("reset take_trap", {31'b0, take_trap}, 32'd0);
        chk("reset redir_valid", {31'b0, redir_valid}, 32'd0);
        chk("reset cause", cause_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R6: sweep of modes, enables and lines
        for (int m = 0; m < 4; m++) begin
            wr_tvec(BASE | 32'(m));
            for (int g = 0; g < 2; g++) begin
                wr_status(g[0], 1'b0, 2'b11);
                for (int p = 0; p < 8; p++) begin
                    for (int e = 0; e < 8; e++) begin
                        logic [2:0] live;
                        logic       et;
                        logic [31:0] tgt;
                        live = 3'(p) & 3'(e);
                        et   = g[0] && (live != 0);
                        tgt  = (m == 1) ? BASE + {26'b0, exp_code(live), 2'b00} : BASE;
                        irq_pend = 3'(p); irq_en = 3'(e); cur_priv = 2'b00;
                        #1;
                        chk(g[0] ? "R2 take" : "R1 gated take", {31'b0, take_trap}, {31'b0, et});
                        if (et) begin
                            chk("R6 target", redir_pc, tgt);
                            chk("R4 machine priv", {30'b0, new_priv}, 32'd3);
                        end
                        irq_pend = '0;
                        @(negedge clk);
                    end
                end
            end
        end

        // R3 R4 R5: entry from user mode, vectored timer
        wr_tvec(BASE | 32'd1);
        wr_status(1'b1, 1'b0, 2'b11);
        pc_i = 32'h2000_0042; cur_priv = 2'b00;
        irq_en = 3'b111; irq_pend = 3'b010;
        #1;
        chk("R2 timer take", {31'b0, redir_valid}, 32'd1);
        chk("R6 timer vector", redir_pc, BASE + 32'd28);
        tick();
        chk("R3 no retake", {31'b0, take_trap}, 32'd0);
        chk("R5 cause", cause_o, 32'h8000_0007);
        irq_pend = '0;
        // R7: MRET returns to user with aligned pc
        mret_i = 1'b1;
        #1;
        chk("R7 mret redir", redir_pc, 32'h2000_0040);
        chk("R4 saved user priv", {30'b0, new_priv}, 32'd0);
        chk("R7 mret valid", {31'b0, redir_valid}, 32'd1);
        tick();
        mret_i = 1'b0;
        irq_pend = 3'b001;
        #1;
        chk("R7 gie restored", {31'b0, take_trap}, 32'd1);
        chk("R6 soft vector", redir_pc, BASE + 32'd12);
        cur_priv = 2'b11;
        tick();
        irq_pend = '0;
        chk("R5 soft cause", cause_o, 32'h8000_0003);
        mret_i = 1'b1;
        #1;
        chk("R4 saved machine priv", {30'b0, new_priv}, 32'd3);
        tick();
        #1;
        chk("R7 pprv lowest", {30'b0, new_priv}, 32'd0);
        tick();
        mret_i = 1'b0;
        irq_pend = 3'b100;
        #1;
        chk("R7 pgie set to 1", {31'b0, take_trap}, 32'd1);
        tick();
        // R8: in handler (gie 0, pgie 1), MRET collides with pending irq
        mret_i = 1'b1;
        #1;
        chk("R8 mret wins", {31'b0, take_trap}, 32'd0);
        chk("R8 redir is epc", {31'b0, redir_valid}, 32'd1);
        tick();
        mret_i = 1'b0;
        #1;
        chk("R8 taken next cycle", {31'b0, take_trap}, 32'd1);
        irq_pend = '0;
        @(negedge clk);
        // R8: restored enable 0 keeps irq blocked
        wr_status(1'b1, 1'b0, 2'b11);
        irq_pend = 3'b100; mret_i = 1'b1;
        #1;
        chk("R8 mret wins gie1", {31'b0, take_trap}, 32'd0);
        tick();
        mret_i = 1'b0;
        #1;
        chk("R8 restored gie0", {31'b0, take_trap}, 32'd0);
        // R9: software re-enables inside handler
        irq_pend = '0;
        wr_status(1'b1, 1'b0, 2'b11);
        irq_pend = 3'b100;
        #1;
        chk("R9 reenabled", {31'b0, take_trap}, 32'd1);
        st_we = 1'b1; st_wdata = st_word(1'b1, 1'b0, 2'b11);
        tick();
        st_we = 1'b0;
        #1;
        chk("R9 trap beats write", {31'b0, take_trap}, 32'd0);
        irq_pend = '0;
        // R10: misaligned epc write
        wr_epc(32'h0000_4567);
        mret_i = 1'b1;
        #1;
        chk("R10 epc aligned", redir_pc, 32'h0000_4564);
        tick();
        mret_i = 1'b0;
        // R11: privilege legalization
        wr_status(1'b0, 1'b0, 2'b01);
        mret_i = 1'b1;
        #1;
        chk("R11 pprv 1 to user", {30'b0, new_priv}, 32'd0);
        tick();
        mret_i = 1'b0;
        wr_status(1'b0, 1'b0, 2'b10);
        mret_i = 1'b1;
        #1;
        chk("R11 pprv 2 to user", {30'b0, new_priv}, 32'd0);
        tick();
        mret_i = 1'b0;
        wr_status(1'b0, 1'b0, 2'b11);
        mret_i = 1'b1;
        #1;
        chk("R11 pprv 3 kept", {30'b0, new_priv}, 32'd3);
        tick();
        mret_i = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule